// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block is the finite-state controller that moves a processor subsystem between the running state and three standby states: a light idle, a clock-stopped state (stop-one) and a power-gated state (stop-two). A two-bit standby-select register names the state to enter. The CPU's sleep request starts the entry. A wake source ends the stay. The wake sources are a maskable interrupt, a non-maskable interrupt, the reset pin and the voltage-detect reset. The block drives the CPU clock enable, the high-speed oscillator enable, a one-cycle warm-up start request to the external warm-up timer, the isolate/power-off request for the main power domain, and a reset request for that domain.

Each standby state has its own exit path. Idle returns to running in the cycle after the wake. Stop-one restarts the oscillator and waits for the warm-up timer to report completion. Stop-two always leaves through a main-domain reset and never through a warm-up, even when an interrupt causes the exit. A wake-cause register keeps the source that ended the last stay, so software can still read it after the main domain has been reset.

Top module: `pwrmode_seq`

## Requirements
- R1: After a synchronous active-low reset the block is running (mode code 0) with cpu_clk_en=1, hosc_en=1, and wu_start, main_iso and main_rst_req all 0. The wake cause is 0 and the select register holds 00. The reset also takes effect from any standby state.
- R2: The select register takes sel_wdata on a clock edge where sel_we=1. The codes are 00 = idle, 01 = stop-one and 10 = stop-two. A sleep_req while running moves the block to the selected state at the next edge. mode_o then reports 1 for idle, 2 for stop-one and 3 for stop-two.
- R3: A sleep_req while the select register holds the reserved code 11 is ignored, and the block stays running.
- R4: In idle, cpu_clk_en=0, hosc_en=1 and main_iso=0. An accepted interrupt or non-maskable interrupt returns the block to running at the next edge, with no warm-up request and no reset request.
- R5: In stop-one, both hosc_en and cpu_clk_en are 0. An accepted interrupt or non-maskable interrupt moves the block to warm-up (mode 4). wu_start is then high for exactly one cycle, and hosc_en returns to 1 in that same cycle. The block stays in warm-up until wu_done=1, then returns to running. wu_done has no effect in any other state.
- R6: In stop-two, main_iso=1 and both cpu_clk_en and hosc_en are 0. The non-maskable interrupt does not release stop-two. An interrupt moves the block to reset-exit (mode 5). main_rst_req=1 there for exactly RST_CYC cycles, then the block returns to running and wu_start never pulses.
- R7: A reset-pin or voltage-detect request in idle, stop-one, stop-two or warm-up moves the block to reset-exit with no warm-up request. main_rst_req stays high for at least RST_CYC cycles and for as long as either source is still active. The block returns to running in the cycle after both sources are released.
- R8: On each exit the wake cause records the highest-priority accepted source. The codes are 1 = interrupt, 2 = non-maskable interrupt, 3 = reset pin and 4 = voltage detect, and priority runs voltage detect > reset pin > non-maskable > interrupt. The value holds until the next exit.
- R9: When a select-register write and a sleep_req fall in the same cycle, the entry uses the value held before the write. The new value applies from the next request.
- R10: Wake inputs while running change neither the outputs nor the wake cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Synchronous active-low reset of the sequencer |
| sel_we | input | 1 | Write strobe for the standby-select register |
| sel_wdata | input | 2 | Standby-select write value |
| sleep_req | input | 1 | CPU request to enter the selected standby state |
| irq_wake | input | 1 | Maskable interrupt wake request |
| nmi_wake | input | 1 | Non-maskable interrupt wake request |
| pin_rst | input | 1 | Reset pin asserted (active high) |
| vdet_rst | input | 1 | Voltage-detect reset asserted |
| wu_done | input | 1 | External warm-up timer has expired |
| cpu_clk_en | output | 1 | CPU clock enable |
| hosc_en | output | 1 | High-speed oscillator enable |
| wu_start | output | 1 | One-cycle warm-up timer start request |
| main_iso | output | 1 | Isolate and power down the main domain |
| main_rst_req | output | 1 | Reset request to the main domain |
| mode_o | output | 3 | Current state: 0 run, 1 idle, 2 stop-one, 3 stop-two, 4 warm-up, 5 reset-exit |
| wake_cause | output | 3 | Source of the last standby exit |

## Verification
A write to the standby-select register and the CPU's sleep request can land on the same clock edge. The bench provokes this by driving both in one vector while the register holds the reserved code. It expects the block to stay running, because the old value decides, and it expects the next lone sleep request to follow the newly written code. Wake sources that coincide are judged the same way: an interrupt with a non-maskable interrupt, and an interrupt with the reset pin. The bench checks that the recorded cause and the exit path follow the higher-priority source.

// File: rtl/pwrmode_pkg.sv
// Shared types of the low-power mode sequencer.
// Assumes: state and cause codes are visible at the ports and fixed.
package pwrmode_pkg;

    typedef enum logic [2:0] {
        PM_RUN   = 3'd0,
        PM_IDLE  = 3'd1,
        PM_STOP1 = 3'd2,
        PM_STOP2 = 3'd3,
        PM_WARM  = 3'd4,
        PM_RSTX  = 3'd5
    } pm_state_e;

    typedef enum logic [1:0] {
        SEL_IDLE  = 2'b00,
        SEL_STOP1 = 2'b01,
        SEL_STOP2 = 2'b10,
        SEL_RSVD  = 2'b11
    } stby_sel_e;

    localparam logic [2:0] WC_NONE = 3'd0;
    localparam logic [2:0] WC_IRQ  = 3'd1;
    localparam logic [2:0] WC_NMI  = 3'd2;
    localparam logic [2:0] WC_PIN  = 3'd3;
    localparam logic [2:0] WC_VDET = 3'd4;

    // Bit positions of the wake-source vector.
    localparam int WS_IRQ  = 0;
    localparam int WS_NMI  = 1;
    localparam int WS_PIN  = 2;
    localparam int WS_VDET = 3;
    localparam int WS_N    = 4;

endpackage

// File: rtl/pwrmode_selreg.sv
// Standby-select register.
// Assumes: a write becomes visible one edge later, so a same-cycle
// sleep request sees the old value.
module pwrmode_selreg
    import pwrmode_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SEL_W-1:0] wdata,
    output logic [SEL_W-1:0] sel_q
);

    // Hold the selected standby code; reset selects idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= SEL_W'(SEL_IDLE);
        else if (we)
            sel_q <= wdata;
    end

endmodule

// File: rtl/pwrmode_wakearb.sv
// Wake-source qualification and priority encoder.
// Assumes: each standby state has its own enable mask; warm-up accepts
// only the two reset sources; running accepts none.
module pwrmode_wakearb
    import pwrmode_pkg::*;
#(
    parameter logic [WS_N-1:0] MASK_IDLE  = 4'b1111,
    parameter logic [WS_N-1:0] MASK_STOP1 = 4'b1111,
    parameter logic [WS_N-1:0] MASK_STOP2 = 4'b1101
) (
    input  pm_state_e        st,
    input  logic [WS_N-1:0]  src,
    output logic             hit,
    output logic             is_rst,
    output logic [2:0]       cause
);

    localparam logic [WS_N-1:0] MASK_RSTONLY = (WS_N)'(1 << WS_PIN) | (WS_N)'(1 << WS_VDET);

    logic [WS_N-1:0] mask;
    logic [WS_N-1:0] eff;

    // Pick the enable mask belonging to the present state.
    always_comb begin
        case (st)
            PM_IDLE:  mask = MASK_IDLE;
            PM_STOP1: mask = MASK_STOP1;
            PM_STOP2: mask = MASK_STOP2;
            PM_WARM:  mask = MASK_RSTONLY;
            default:  mask = '0;
        endcase
    end

    // Qualify each source with its mask bit.
    for (genvar g = 0; g < WS_N; g++) begin : g_qual
        assign eff[g] = src[g] & mask[g];
    end

    // Encode the winner: voltage detect, pin, NMI, interrupt.
    always_comb begin
        hit    = |eff;
        is_rst = eff[WS_PIN] | eff[WS_VDET];
        if (eff[WS_VDET])
            cause = WC_VDET;
        else if (eff[WS_PIN])
            cause = WC_PIN;
        else if (eff[WS_NMI])
            cause = WC_NMI;
        else if (eff[WS_IRQ])
            cause = WC_IRQ;
        else
            cause = WC_NONE;
    end

endmodule

// File: rtl/pwrmode_fsm.sv
// Mode state machine with the reset-exit hold counter and cause register.
// Assumes: wake qualification is done by the arbiter; rst_src is the raw
// OR of the pin and voltage-detect requests.
module pwrmode_fsm
    import pwrmode_pkg::*;
#(
    parameter int RST_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_req,
    input  logic [1:0] sel,
    input  logic       hit,
    input  logic       is_rst,
    input  logic [2:0] cause,
    input  logic       rst_src,
    input  logic       wu_done,
    output pm_state_e  st_q,
    output logic       wu_start_q,
    output logic [2:0] cause_q
);

    localparam int CW = (RST_CYC > 1) ? $clog2(RST_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(RST_CYC - 1);

    pm_state_e   st_d;
    logic        wu_d;
    logic [2:0]  cause_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // Next-state, warm-up request, cause capture and hold counter.
    always_comb begin
        st_d    = st_q;
        wu_d    = 1'b0;
        cause_d = cause_q;
        cnt_d   = cnt_q;
        case (st_q)
            PM_RUN: begin
                if (sleep_req) begin
                    case (stby_sel_e'(sel))
                        SEL_IDLE:  st_d = PM_IDLE;
                        SEL_STOP1: st_d = PM_STOP1;
                        SEL_STOP2: st_d = PM_STOP2;
                        default:   st_d = PM_RUN;
                    endcase
                end
            end
            PM_IDLE, PM_STOP1, PM_STOP2: begin
                if (hit) begin
                    cause_d = cause;
                    cnt_d   = '0;
                    if (is_rst || st_q == PM_STOP2) begin
                        st_d = PM_RSTX;
                    end else if (st_q == PM_STOP1) begin
                        st_d = PM_WARM;
                        wu_d = 1'b1;
                    end else begin
                        st_d = PM_RUN;
                    end
                end
            end
            PM_WARM: begin
                if (hit) begin
                    cause_d = cause;
                    cnt_d   = '0;
                    st_d    = PM_RSTX;
                end else if (wu_done) begin
                    st_d = PM_RUN;
                end
            end
            PM_RSTX: begin
                if (cnt_q >= LAST) begin
                    if (!rst_src)
                        st_d = PM_RUN;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: st_d = PM_RUN;
        endcase
    end

    // State, pulse, cause and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= PM_RUN;
            wu_start_q <= 1'b0;
            cause_q    <= WC_NONE;
            cnt_q      <= '0;
        end else begin
            st_q       <= st_d;
            wu_start_q <= wu_d;
            cause_q    <= cause_d;
            cnt_q      <= cnt_d;
        end
    end

endmodule

// File: rtl/pwrmode_outdec.sv
// Decodes the state into the clock, oscillator and power-domain controls.
// Assumes: the warm-up pulse is registered elsewhere and only passed on.
module pwrmode_outdec
    import pwrmode_pkg::*;
(
    input  pm_state_e st,
    output logic      cpu_clk_en,
    output logic      hosc_en,
    output logic      main_iso,
    output logic      main_rst_req
);

    // One control set per state.
    always_comb begin
        cpu_clk_en   = 1'b0;
        hosc_en      = 1'b1;
        main_iso     = 1'b0;
        main_rst_req = 1'b0;
        case (st)
            PM_RUN:   cpu_clk_en = 1'b1;
            PM_IDLE:  hosc_en    = 1'b1;
            PM_STOP1: hosc_en    = 1'b0;
            PM_STOP2: begin
                hosc_en  = 1'b0;
                main_iso = 1'b1;
            end
            PM_WARM:  hosc_en    = 1'b1;
            PM_RSTX:  main_rst_req = 1'b1;
            default:  cpu_clk_en = 1'b1;
        endcase
    end

endmodule

// File: rtl/pwrmode_seq.sv
// Low-power mode sequencer top: select register, wake arbiter, state
// machine and output decoder.
// Assumes: all inputs are synchronous to clk; the warm-up timer and
// power switches are external.
module pwrmode_seq
    import pwrmode_pkg::*;
#(
    parameter int               RST_CYC    = 4,
    parameter logic [WS_N-1:0]  MASK_IDLE  = 4'b1111,
    parameter logic [WS_N-1:0]  MASK_STOP1 = 4'b1111,
    parameter logic [WS_N-1:0]  MASK_STOP2 = 4'b1101
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_we,
    input  logic [1:0] sel_wdata,
    input  logic       sleep_req,
    input  logic       irq_wake,
    input  logic       nmi_wake,
    input  logic       pin_rst,
    input  logic       vdet_rst,
    input  logic       wu_done,
    output logic       cpu_clk_en,
    output logic       hosc_en,
    output logic       wu_start,
    output logic       main_iso,
    output logic       main_rst_req,
    output logic [2:0] mode_o,
    output logic [2:0] wake_cause
);

    logic [1:0]      sel_q;
    logic [WS_N-1:0] src;
    logic            hit, is_rst;
    logic [2:0]      cause;
    pm_state_e       st;

    // Gather the wake sources into one vector.
    always_comb begin
        src          = '0;
        src[WS_IRQ]  = irq_wake;
        src[WS_NMI]  = nmi_wake;
        src[WS_PIN]  = pin_rst;
        src[WS_VDET] = vdet_rst;
    end

    pwrmode_selreg #(.SEL_W(2)) u_sel (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (sel_we),
        .wdata (sel_wdata),
        .sel_q (sel_q)
    );

    pwrmode_wakearb #(
        .MASK_IDLE  (MASK_IDLE),
        .MASK_STOP1 (MASK_STOP1),
        .MASK_STOP2 (MASK_STOP2)
    ) u_arb (
        .st     (st),
        .src    (src),
        .hit    (hit),
        .is_rst (is_rst),
        .cause  (cause)
    );

    pwrmode_fsm #(.RST_CYC(RST_CYC)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep_req  (sleep_req),
        .sel        (sel_q),
        .hit        (hit),
        .is_rst     (is_rst),
        .cause      (cause),
        .rst_src    (pin_rst | vdet_rst),
        .wu_done    (wu_done),
        .st_q       (st),
        .wu_start_q (wu_start),
        .cause_q    (wake_cause)
    );

    pwrmode_outdec u_dec (
        .st           (st),
        .cpu_clk_en   (cpu_clk_en),
        .hosc_en      (hosc_en),
        .main_iso     (main_iso),
        .main_rst_req (main_rst_req)
    );

    // Present the state code at the port.
    assign mode_o = st;

endmodule

// File: rtl/pwrmode_seq_chk.sv
// Property checker for pwrmode_seq, attached by bind.
// Assumes: port codes as in the brief; RST_CYC matches the bound block.
module pwrmode_seq_chk #(
    parameter int RST_CYC = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       sleep_req,
    input logic       nmi_wake,
    input logic [1:0] sel_i,
    input logic       cpu_clk_en,
    input logic       hosc_en,
    input logic       wu_start,
    input logic       main_iso,
    input logic       main_rst_req,
    input logic [2:0] mode_o,
    input logic [2:0] wake_cause
);

    logic [15:0] run_q;

    // Count consecutive cycles of main-domain reset request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= '0;
        else if (main_rst_req)
            run_q <= (run_q == 16'hFFFF) ? run_q : run_q + 16'd1;
        else
            run_q <= '0;
    end

    p_hosc_with_wu_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wu_start |-> hosc_en);

    p_wu_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wu_start |=> !wu_start);

    p_rst_no_wu_r7: assert property (@(posedge clk) disable iff (!rst_n)
        main_rst_req |-> !wu_start);

    p_iso_clocks_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        main_iso |-> (!cpu_clk_en && !hosc_en && !main_rst_req));

    p_reserved_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd0 && sleep_req && sel_i == 2'b11) |=> mode_o == 3'd0);

    p_stop2_via_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd3 && nmi_wake) |=> (mode_o == 3'd3 || mode_o == 3'd5));

    p_rst_min_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!main_rst_req && run_q != 16'd0) |-> run_q >= 16'(RST_CYC));

    p_cause_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd0 && $past(mode_o) == 3'd0) |-> $stable(wake_cause));

    p_idle_osc_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd1) |-> (hosc_en && !cpu_clk_en && !main_iso));

endmodule

bind pwrmode_seq pwrmode_seq_chk #(.RST_CYC(RST_CYC)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sleep_req    (sleep_req),
    .nmi_wake     (nmi_wake),
    .sel_i        (sel_q),
    .cpu_clk_en   (cpu_clk_en),
    .hosc_en      (hosc_en),
    .wu_start     (wu_start),
    .main_iso     (main_iso),
    .main_rst_req (main_rst_req),
    .mode_o       (mode_o),
    .wake_cause   (wake_cause)
);

// File: tb/pwrmode_seq_bench.sv
`timescale 1ns/1ps
module pwrmode_seq_bench;

    localparam int RST_CYC = 3;
    localparam int NV = 38;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_we = 1'b0;
    logic [1:0] sel_wdata = 2'b00;
    logic sleep_req = 1'b0, irq_wake = 1'b0, nmi_wake = 1'b0;
    logic pin_rst = 1'b0, vdet_rst = 1'b0, wu_done = 1'b0;
    logic cpu_clk_en, hosc_en, wu_start, main_iso, main_rst_req;
    logic [2:0] mode_o, wake_cause;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pwrmode_seq #(.RST_CYC(RST_CYC)) u_pwrmode_seq (
        .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .sel_wdata(sel_wdata),
        .sleep_req(sleep_req), .irq_wake(irq_wake), .nmi_wake(nmi_wake),
        .pin_rst(pin_rst), .vdet_rst(vdet_rst), .wu_done(wu_done),
        .cpu_clk_en(cpu_clk_en), .hosc_en(hosc_en), .wu_start(wu_start),
        .main_iso(main_iso), .main_rst_req(main_rst_req),
        .mode_o(mode_o), .wake_cause(wake_cause)
    );

    // Vector: {req[3:0], in{we,wd[1:0],slp,irq,nmi,pin,vdet,wud}, exp{mode[2:0],cpu,hosc,wu,iso,rst,cause[2:0]}}
    localparam logic [23:0] VEC [NV] = '{
        {4'd2,  9'b0_00_1_00000, 3'd1, 5'b01000, 3'd0}, // R2 sleep -> idle
        {4'd4,  9'b0_00_0_00000, 3'd1, 5'b01000, 3'd0}, // R4 idle holds
        {4'd4,  9'b0_00_0_01000, 3'd0, 5'b11000, 3'd2}, // R4 NMI exits idle
        {4'd2,  9'b1_01_0_00000, 3'd0, 5'b11000, 3'd2}, // R2 select stop-one
        {4'd2,  9'b0_00_1_00000, 3'd2, 5'b00000, 3'd2}, // R2 enter stop-one
        {4'd5,  9'b0_00_0_00001, 3'd2, 5'b00000, 3'd2}, // R5 stray wu_done ignored
        {4'd5,  9'b0_00_0_10000, 3'd4, 5'b01100, 3'd1}, // R5 warm-up pulse with osc on
        {4'd5,  9'b0_00_0_00000, 3'd4, 5'b01000, 3'd1}, // R5 pulse is single
        {4'd5,  9'b0_00_0_00001, 3'd0, 5'b11000, 3'd1}, // R5 done -> run
        {4'd2,  9'b1_10_0_00000, 3'd0, 5'b11000, 3'd1}, // R2 select stop-two
        {4'd6,  9'b0_00_1_00000, 3'd3, 5'b00010, 3'd1}, // R6 enter stop-two
        {4'd6,  9'b0_00_0_01000, 3'd3, 5'b00010, 3'd1}, // R6 NMI masked
        {4'd6,  9'b0_00_0_10000, 3'd5, 5'b01001, 3'd1}, // R6 irq -> reset exit
        {4'd6,  9'b0_00_0_00000, 3'd5, 5'b01001, 3'd1}, // R6
        {4'd6,  9'b0_00_0_00000, 3'd5, 5'b01001, 3'd1}, // R6
        {4'd6,  9'b0_00_0_00000, 3'd0, 5'b11000, 3'd1}, // R6 after RST_CYC
        {4'd3,  9'b1_11_0_00000, 3'd0, 5'b11000, 3'd1}, // R3 write reserved
        {4'd3,  9'b0_00_1_00000, 3'd0, 5'b11000, 3'd1}, // R3 sleep ignored
        {4'd9,  9'b1_01_1_00000, 3'd0, 5'b11000, 3'd1}, // R9 write+sleep same cycle
        {4'd9,  9'b0_00_1_00000, 3'd2, 5'b00000, 3'd1}, // R9 new value next time
        {4'd7,  9'b0_00_0_00100, 3'd5, 5'b01001, 3'd3}, // R7 pin in stop-one
        {4'd7,  9'b0_00_0_00100, 3'd5, 5'b01001, 3'd3}, // R7
        {4'd7,  9'b0_00_0_00100, 3'd5, 5'b01001, 3'd3}, // R7
        {4'd7,  9'b0_00_0_00100, 3'd5, 5'b01001, 3'd3}, // R7 held by pin
        {4'd7,  9'b0_00_0_00000, 3'd0, 5'b11000, 3'd3}, // R7 release
        {4'd10, 9'b0_00_0_11010, 3'd0, 5'b11000, 3'd3}, // R10 wakes while running
        {4'd2,  9'b0_00_1_00000, 3'd2, 5'b00000, 3'd3}, // R2 stop-one again
        {4'd8,  9'b0_00_0_11000, 3'd4, 5'b01100, 3'd2}, // R8 NMI beats irq
        {4'd7,  9'b0_00_0_00010, 3'd5, 5'b01001, 3'd4}, // R7 vdet during warm-up
        {4'd7,  9'b0_00_0_00000, 3'd5, 5'b01001, 3'd4}, // R7
        {4'd7,  9'b0_00_0_00000, 3'd5, 5'b01001, 3'd4}, // R7
        {4'd7,  9'b0_00_0_00000, 3'd0, 5'b11000, 3'd4}, // R7
        {4'd2,  9'b1_00_0_00000, 3'd0, 5'b11000, 3'd4}, // R2 select idle
        {4'd2,  9'b0_00_1_00000, 3'd1, 5'b01000, 3'd4}, // R2
        {4'd8,  9'b0_00_0_10100, 3'd5, 5'b01001, 3'd3}, // R8 pin beats irq
        {4'd8,  9'b0_00_0_00000, 3'd5, 5'b01001, 3'd3}, // R8
        {4'd8,  9'b0_00_0_00000, 3'd5, 5'b01001, 3'd3}, // R8
        {4'd8,  9'b0_00_0_00000, 3'd0, 5'b11000, 3'd3}  // R8
    };

    // Compare one value and report a miscompare.
    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
        end
    endtask

    // Drive one input set after a falling edge, sample after the next rising edge.
    task automatic step(input logic [8:0] in);
        @(negedge clk);
        {sel_we, sel_wdata, sleep_req, irq_wake, nmi_wake, pin_rst, vdet_rst, wu_done} = in;
        @(posedge clk);
        #1;
    endtask

    function automatic logic [10:0] outs();
        return {mode_o, cpu_clk_en, hosc_en, wu_start, main_iso, main_rst_req, wake_cause};
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 reset state", int'(outs()), int'({3'd0, 5'b11000, 3'd0}));

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][19:11]);
            checks++;
            if (outs() !== VEC[i][10:0]) begin
                fails++;
                $display("FAIL R%0d vector %0d got=%b exp=%b", VEC[i][23:20], i, outs(), VEC[i][10:0]);
            end
        end

        // R6/R7: stop-two held in reset-exit by a long voltage-detect request.
        step(9'b1_10_0_00000);
        step(9'b0_00_1_00000);
        chk("R6 stop-two iso", int'({mode_o, main_iso, hosc_en}), int'({3'd3, 1'b1, 1'b0}));
        for (int k = 0; k < 5; k++) begin
            step(9'b0_00_0_00010);
            chk("R7 vdet hold", int'({mode_o, main_rst_req, wake_cause}), int'({3'd5, 1'b1, 3'd4}));
        end
        step(9'b0_00_0_00000);
        chk("R7 release", int'({mode_o, main_rst_req}), int'({3'd0, 1'b0}));

        // R5: warm-up waits for the timer however long it takes.
        step(9'b1_01_0_00000);
        step(9'b0_00_1_00000);
        step(9'b0_00_0_10000);
        chk("R5 warm entry", int'({mode_o, wu_start, hosc_en}), int'({3'd4, 1'b1, 1'b1}));
        for (int k = 0; k < 10; k++) begin
            step(9'b0_00_0_00000);
            chk("R5 warm wait", int'({mode_o, wu_start, hosc_en}), int'({3'd4, 1'b0, 1'b1}));
        end
        step(9'b0_00_0_00001);
        chk("R5 warm done", int'(mode_o), 0);

        // R1: reset from stop-two clears state, cause and select register.
        step(9'b1_10_0_00000);
        step(9'b0_00_1_00000);
        chk("R1 pre-reset stop-two", int'(mode_o), 3);
        @(negedge clk);
        {sel_we, sel_wdata, sleep_req, irq_wake, nmi_wake, pin_rst, vdet_rst, wu_done} = '0;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 reset from stop-two", int'(outs()), int'({3'd0, 5'b11000, 3'd0}));
        step(9'b0_00_1_00000);
        chk("R1 select back to idle", int'(mode_o), 1);
        step(9'b0_00_0_10000);
        chk("R4 irq exits idle", int'({mode_o, wu_start, wake_cause}), int'({3'd0, 1'b0, 3'd1}));

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired got=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule